// File: doc/BRIEF.md
# DDR SDRAM Refresh and Self-Refresh Sequencer

This block lives inside a DDR SDRAM memory controller and owns every refresh the memory receives. An interval timer adds one owed refresh each time a refresh period elapses. The block then requests the command bus from the main scheduler. Once it holds a grant while all banks are idle, it issues a single auto-refresh command and keeps the scheduler off the bus for the refresh recovery time. Up to eight owed refreshes can be postponed while the scheduler withholds the bus.

The block also runs the low-power self-refresh mode. When the controller asks for low power and no refresh is owed, the block drives an auto-refresh encoding in the same cycle that it pulls CKE low. CKE then stays low for as long as the mode lasts. To leave the mode, the block waits until the clock is reported stable before it raises CKE. It then drives only NOPs for a fixed 200-cycle window. That window covers both the completion of any internal refresh and the relock of the memory's delay-locked loop, so normal commands and reads are allowed only once it ends. The interval timer is held during self refresh and starts again from zero when the window ends.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset the block drives CKE high, a NOP on the command pins (cs_n=0, ras_n=1, cas_n=1, we_n=1), ref_req_o low and sched_ok_o high.
- R2: After reset is released, ref_req_o first rises on the observation following clock edge REFI_CYC+1, counting the first edge with reset low as edge 1.
- R3: An auto-refresh is driven for exactly one cycle as cs_n=0, ras_n=0, cas_n=0, we_n=1 with CKE high. It appears in the cycle after the edge at which ref_req_o, grant_i and banks_idle_i are all high, and ref_req_o is low in that same cycle.
- R4: A grant while banks_idle_i is low issues no command, and ref_req_o stays high.
- R5: sched_ok_o is low for exactly RFC_CYC cycles starting with the auto-refresh cycle, and the command pins carry NOPs after the auto-refresh.
- R6: Every elapsed interval owes one separate auto-refresh. When grants are withheld for N intervals, N auto-refreshes follow once the bus is granted, with at most 8 owed (the count saturates).
- R7: Self refresh is entered only when no refresh is owed; owed refreshes are issued first as normal auto-refreshes with CKE high. The entry cycle shows the auto-refresh encoding with CKE going low in that same cycle.
- R8: While in self refresh, CKE stays low, ref_req_o stays low and sched_ok_o stays low, whatever number of intervals pass.
- R9: With the low-power request released, CKE stays low until clk_stable_i is high. CKE rises in the cycle after the edge at which both conditions hold.
- R10: From the first cycle with CKE high, exactly EXIT_NOP_CYC (200) cycles carry NOPs with sched_ok_o low. sched_ok_o, which also allows reads, returns high in the next cycle.
- R11: The interval timer restarts on exit: ref_req_o rises REFI_CYC+1 edges after sched_ok_o returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_want_i | input | 1 | Level request to be in self refresh |
| clk_stable_i | input | 1 | Memory clock is running and stable |
| banks_idle_i | input | 1 | All banks precharged, from the scheduler |
| grant_i | input | 1 | Scheduler hands the command bus to this block |
| ref_req_o | output | 1 | Request for the command bus |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable to the memory |
| sched_ok_o | output | 1 | Scheduler may issue commands, reads included |

## Verification
The owed-refresh count cannot be seen directly. A wrong count therefore shows up as the wrong number of auto-refresh pulses in the burst that follows a grant, and it shows within one burst. A timer that is off by even one cycle moves the rise of ref_req_o, so the bench measures that rise to the exact edge, both after reset and after self-refresh exit. A state machine that leaves the exit window early or late shows up as sched_ok_o rising on the wrong cycle, and the bench counts the 200 NOP cycles one by one. An entry taken while a refresh is owed shows up as CKE falling on the first auto-refresh instead of a later one.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } dram_cmd_t;

    localparam dram_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam dram_cmd_t CMD_AREF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

    typedef enum logic [2:0] {
        SQ_RUN,   // scheduler owns the bus
        SQ_ARB,   // bus requested, waiting for grant and idle banks
        SQ_RFC,   // refresh recovery hold
        SQ_SELF,  // CKE low, self refresh
        SQ_XNOP   // exit window, NOPs only
    } seq_state_t;

    function automatic logic is_aref(dram_cmd_t c);
        return c == CMD_AREF;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int REFI_CYC = 780,
    parameter int MAX_PEND = 8,
    parameter int PEND_W   = $clog2(MAX_PEND + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              clr_i,
    input  logic              dec_i,
    output logic [PEND_W-1:0] pend_o
);
    localparam int TW = (REFI_CYC > 2) ? $clog2(REFI_CYC) : 1;

    logic [TW-1:0] tmr_q;
    logic          tick;

    assign tick = run_i && (tmr_q == TW'(REFI_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            tmr_q <= '0;
        end else if (tick) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            pend_o <= '0;
        end else if (tick && !dec_i) begin
            if (pend_o != PEND_W'(MAX_PEND)) pend_o <= pend_o + 1'b1;
        end else if (dec_i && !tick) begin
            if (pend_o != '0) pend_o <= pend_o - 1'b1;
        end
    end

    p_pend_cap_r6: assert property (@(posedge clk) disable iff (rst)
        pend_o <= PEND_W'(MAX_PEND));

    p_tick_step_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && !dec_i && !clr_i && pend_o < PEND_W'(MAX_PEND))
            |=> (pend_o == $past(pend_o) + 1'b1));

endmodule

// File: rtl/rfsh_seq_fsm.sv
module rfsh_seq_fsm
    import rfsh_pkg::*;
#(
    parameter int RFC_CYC      = 8,
    parameter int EXIT_NOP_CYC = 200,
    parameter int PEND_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PEND_W-1:0] pend_i,
    input  logic              lp_want_i,
    input  logic              clk_stable_i,
    input  logic              grant_i,
    input  logic              banks_idle_i,
    output logic              ref_req_o,
    output dram_cmd_t         cmd_o,
    output logic              cke_o,
    output logic              sched_ok_o,
    output logic              timer_run_o,
    output logic              pend_clr_o,
    output logic              pend_dec_o
);
    localparam int WMAX = max_u(RFC_CYC, EXIT_NOP_CYC);
    localparam int WW   = $clog2(WMAX + 1);

    seq_state_t    st_q;
    dram_cmd_t     cmd_q;
    logic          cke_q;
    logic          go_sr_q;
    logic [WW-1:0] wcnt_q;
    logic          fire;

    assign fire        = (st_q == SQ_ARB) && grant_i && banks_idle_i;
    assign ref_req_o   = (st_q == SQ_ARB);
    assign sched_ok_o  = (st_q == SQ_RUN) || (st_q == SQ_ARB);
    assign timer_run_o = (st_q == SQ_RUN) || (st_q == SQ_ARB) || (st_q == SQ_RFC);
    assign pend_clr_o  = (st_q == SQ_SELF);
    assign pend_dec_o  = fire && !go_sr_q;
    assign cmd_o       = cmd_q;
    assign cke_o       = cke_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SQ_RUN;
            cmd_q   <= CMD_NOP;
            cke_q   <= 1'b1;
            go_sr_q <= 1'b0;
            wcnt_q  <= '0;
        end else begin
            cmd_q <= CMD_NOP;
            unique case (st_q)
                SQ_RUN: begin
                    if (pend_i != '0 || lp_want_i) begin
                        st_q    <= SQ_ARB;
                        go_sr_q <= (pend_i == '0) && lp_want_i;
                    end
                end
                SQ_ARB: begin
                    if (fire) begin
                        cmd_q <= CMD_AREF;
                        if (go_sr_q) begin
                            cke_q <= 1'b0;
                            st_q  <= SQ_SELF;
                        end else begin
                            wcnt_q <= WW'(RFC_CYC - 1);
                            st_q   <= SQ_RFC;
                        end
                    end
                end
                SQ_SELF: begin
                    if (!lp_want_i && clk_stable_i) begin
                        cke_q  <= 1'b1;
                        wcnt_q <= WW'(EXIT_NOP_CYC - 1);
                        st_q   <= SQ_XNOP;
                    end
                end
                SQ_RFC, SQ_XNOP: begin
                    if (wcnt_q == '0) st_q <= SQ_RUN;
                    else              wcnt_q <= wcnt_q - 1'b1;
                end
                default: st_q <= SQ_RUN;
            endcase
        end
    end

    p_ar_single_r3: assert property (@(posedge clk) disable iff (rst)
        is_aref(cmd_q) |=> (cmd_q == CMD_NOP));

    p_issue_gate_r4: assert property (@(posedge clk) disable iff (rst)
        is_aref(cmd_q) |-> $past(grant_i && banks_idle_i));

    p_sr_entry_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(cke_q) |-> is_aref(cmd_q));

    p_sr_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !cke_q |-> (!ref_req_o && !sched_ok_o));

    p_exit_stable_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(cke_q) |-> $past(clk_stable_i && !lp_want_i));

    p_exit_hold_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(cke_q) |-> (!sched_ok_o && cmd_q == CMD_NOP));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import rfsh_pkg::*;
#(
    parameter int REFI_CYC     = 780,
    parameter int RFC_CYC      = 8,
    parameter int EXIT_NOP_CYC = 200,
    parameter int MAX_PEND     = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic lp_want_i,
    input  logic clk_stable_i,
    input  logic banks_idle_i,
    input  logic grant_i,
    output logic ref_req_o,
    output logic cs_n_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic we_n_o,
    output logic cke_o,
    output logic sched_ok_o
);
    localparam int PEND_W = $clog2(MAX_PEND + 1);

    logic [PEND_W-1:0] pend;
    logic              timer_run;
    logic              pend_clr;
    logic              pend_dec;
    dram_cmd_t         cmd;

    rfsh_interval_timer #(
        .REFI_CYC (REFI_CYC),
        .MAX_PEND (MAX_PEND),
        .PEND_W   (PEND_W)
    ) timer_i (
        .clk    (clk),
        .rst    (rst),
        .run_i  (timer_run),
        .clr_i  (pend_clr),
        .dec_i  (pend_dec),
        .pend_o (pend)
    );

    rfsh_seq_fsm #(
        .RFC_CYC      (RFC_CYC),
        .EXIT_NOP_CYC (EXIT_NOP_CYC),
        .PEND_W       (PEND_W)
    ) fsm_i (
        .clk          (clk),
        .rst          (rst),
        .pend_i       (pend),
        .lp_want_i    (lp_want_i),
        .clk_stable_i (clk_stable_i),
        .grant_i      (grant_i),
        .banks_idle_i (banks_idle_i),
        .ref_req_o    (ref_req_o),
        .cmd_o        (cmd),
        .cke_o        (cke_o),
        .sched_ok_o   (sched_ok_o),
        .timer_run_o  (timer_run),
        .pend_clr_o   (pend_clr),
        .pend_dec_o   (pend_dec)
    );

    assign cs_n_o  = cmd.cs_n;
    assign ras_n_o = cmd.ras_n;
    assign cas_n_o = cmd.cas_n;
    assign we_n_o  = cmd.we_n;

endmodule

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int REFI  = 64;
    localparam int RFC   = 4;
    localparam int XNOP  = 200;
    localparam int NVEC  = 5;
    localparam int VEC_N [NVEC] = '{0, 1, 3, 8, 10};
    localparam int VEC_E [NVEC] = '{0, 1, 3, 8, 8};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lp_want = 1'b0;
    logic clk_stable = 1'b1;
    logic banks_idle = 1'b1;
    logic grant = 1'b0;
    logic ref_req, cs_n, ras_n, cas_n, we_n, cke, sched_ok;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_refresh_seq #(
        .REFI_CYC (REFI), .RFC_CYC (RFC), .EXIT_NOP_CYC (XNOP), .MAX_PEND (8)
    ) dut_i (
        .clk (clk), .rst (rst), .lp_want_i (lp_want), .clk_stable_i (clk_stable),
        .banks_idle_i (banks_idle), .grant_i (grant), .ref_req_o (ref_req),
        .cs_n_o (cs_n), .ras_n_o (ras_n), .cas_n_o (cas_n), .we_n_o (we_n),
        .cke_o (cke), .sched_ok_o (sched_ok)
    );

    function automatic bit is_ar();
        return {cs_n, ras_n, cas_n, we_n} == 4'b0001;
    endfunction

    function automatic bit is_nop();
        return {cs_n, ras_n, cas_n, we_n} == 4'b0111;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; grant = 1'b0; lp_want = 1'b0; banks_idle = 1'b1; clk_stable = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic wait_ar(output bit seen, output bit cke_at);
        seen = 1'b0; cke_at = 1'b0;
        for (int i = 0; i < 60 && !seen; i++) begin
            @(negedge clk);
            if (is_ar()) begin seen = 1'b1; cke_at = cke; end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        bit bad;
        bit seen;
        bit ck;

        // R1 reset state
        do_reset();
        check(cke == 1'b1, "R1 cke", cke, 1);
        check(is_nop(), "R1 nop", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        check(ref_req == 1'b0, "R1 ref_req", ref_req, 0);
        check(sched_ok == 1'b1, "R1 sched_ok", sched_ok, 1);

        // R2 first request timing
        n = 0;
        for (int i = 0; i < 4 * REFI; i++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (ref_req) break;
        end
        check(n == REFI + 1, "R2 first ref_req edge", n, REFI + 1);

        // R4 grant without idle banks
        grant = 1'b1; banks_idle = 1'b0;
        bad = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (!is_nop() || !ref_req) bad = 1'b1;
        end
        check(!bad, "R4 no issue while banks busy", bad, 0);

        // R3 issue
        banks_idle = 1'b1;
        @(negedge clk);
        check(is_ar() && cke, "R3 auto-refresh encoding", {cs_n, ras_n, cas_n, we_n}, 4'b0001);
        check(!ref_req, "R3 ref_req drops", ref_req, 0);
        grant = 1'b0;
        // R5 recovery hold
        n = 0; bad = 1'b0;
        if (!sched_ok) n++;
        for (int i = 1; i < RFC; i++) begin
            @(negedge clk);
            if (!sched_ok) n++;
            if (!is_nop()) bad = 1'b1;
        end
        check(n == RFC, "R5 sched_ok low cycles", n, RFC);
        check(!bad, "R5 nop after refresh", bad, 0);
        @(negedge clk);
        check(sched_ok, "R5 sched_ok returns", sched_ok, 1);

        // R6 table of postponed-interval counts
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            repeat (VEC_N[v] * REFI) @(posedge clk);
            @(negedge clk) grant = 1'b1;
            n = 0;
            repeat (56) begin
                @(negedge clk);
                if (is_ar()) n++;
            end
            check(n == VEC_E[v], "R6 refreshes after postponing", n, VEC_E[v]);
        end

        // R7 entry with an owed refresh
        do_reset();
        repeat (REFI) @(posedge clk);
        @(negedge clk);
        lp_want = 1'b1; grant = 1'b1;
        wait_ar(seen, ck);
        check(seen && ck, "R7 owed refresh first with cke high", ck, 1);
        wait_ar(seen, ck);
        check(seen && !ck, "R7 entry refresh with cke low", ck, 0);
        grant = 1'b0;

        // R8 hold in self refresh
        clk_stable = 1'b0;
        bad = 1'b0;
        repeat (3 * REFI) begin
            @(negedge clk);
            if (cke || ref_req || sched_ok) bad = 1'b1;
        end
        check(!bad, "R8 quiet in self refresh", bad, 0);

        // R9 wait for stable clock
        lp_want = 1'b0;
        bad = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (cke) bad = 1'b1;
        end
        check(!bad, "R9 cke low until clock stable", bad, 0);
        clk_stable = 1'b1;
        @(negedge clk);
        check(cke, "R9 cke rises", cke, 1);

        // R10 exit NOP window
        n = 0; bad = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (sched_ok) break;
            n++;
            if (!cke || !is_nop()) bad = 1'b1;
            @(negedge clk);
        end
        check(n == XNOP, "R10 exit window length", n, XNOP);
        check(!bad, "R10 nop only in window", bad, 0);

        // R11 timer restart
        n = 0;
        for (int i = 0; i < 4 * REFI; i++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (ref_req) break;
        end
        check(n == REFI + 1, "R11 first ref_req after exit", n, REFI + 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule